// File: doc/BRIEF.md
# Rader Index Permutation Generator

This block produces the address streams that reorder the samples of a prime-length DFT, so that its non-DC terms become a cyclic convolution of length N-1. It takes a prime length N of at most 31 and a primitive root g, both sampled on a start pulse. It first emits one beat for index 0, which is flagged so that the DC sum can be routed to its own path. It then emits the input reordering sequence g^q mod N for q = 0..N-2. Last comes the output reordering sequence, built from the inverse root h = g^(N-2) mod N, which returns the convolution result to natural order.

Each new address is the previous one multiplied by the active root and reduced modulo N. The reduction is a restoring compare-subtract loop with one step per bit of the length, and no divider is used. If the input sequence comes back to 1 before N-1 addresses have been produced, the root is not primitive. In that case the block stops and raises a sticky error. The samples themselves and the convolution arithmetic are handled outside this block.

Top module: `rader_perm_gen`

## Requirements
- R1: During and after reset the block is idle: addr_valid, busy and err_flag are all 0.
- R2: After a start with legal operands, the first beat (one clock after the start edge) has addr_out=0, dc_flag=1 and seq_sel=0. The next clock carries addr_out=1.
- R3: The input sequence has exactly N-1 beats with seq_sel=0, and beat q carries g^q mod N.
- R4: addr_last is 1 on the final beat of each sequence and 0 on every other beat, including the DC beat.
- R5: The output sequence begins on the clock after the input sequence's last beat. It has N-1 beats with seq_sel=1, and beat p carries h^p mod N, where h = g^(N-2) mod N.
- R6: For every prime N up to 31 with a primitive root, each sequence holds every index 1..N-1 exactly once and never holds 0.
- R7: Within one sequence, consecutive beats are exactly WIDTH+2 clocks apart (7 by default), and addr_valid is low in between.
- R8: If the input sequence reaches 1 again before N-1 beats, err_flag goes to 1 and busy falls in the same clock. No further beats follow, and err_flag holds until the next start.
- R9: A start with N<2, g=0 or g>=N produces no beats and sets err_flag one clock later. A start with legal operands clears err_flag.
- R10: A start while busy abandons the current run and begins again with the DC beat for the new operands.
- R11: busy is 1 from the clock after a legal start until the final output beat. It is 0 on the clock after that beat, and addr_valid is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads len_in and root_in and begins a run |
| len_in | input | WIDTH | Prime transform length N |
| root_in | input | WIDTH | Primitive root g of N |
| addr_valid | output | 1 | An address beat is present |
| addr_out | output | WIDTH | Permuted index |
| addr_last | output | 1 | Final beat of the current sequence |
| seq_sel | output | 1 | 0 for the input sequence, 1 for the output sequence |
| dc_flag | output | 1 | The beat is index 0, the DC term |
| err_flag | output | 1 | Illegal operands, or a root that is not primitive |
| busy | output | 1 | A run is in progress |

## Verification
The bench runs every prime from 2 to 31 with its smallest primitive root and compares each sequence against powers computed independently in the bench. A faulty modular reduction would produce a repeated or out-of-range index, and the per-sequence occupancy check reports it. The smallest case, N=2, has one-beat sequences that are both first and last; an off-by-one in the terminal count would emit an extra beat or drop the output sequence. The root 2 for N=7 returns to 1 after three steps: a design that missed this would carry on with a repeating stream instead of stopping with the error flag. Illegal operands, which would otherwise send the loop into a zero or non-terminating cycle, and a restart in mid-run are also driven.

// File: rtl/rader_perm_gen.sv
module rader_perm_gen #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] len_in,
  input  logic [WIDTH-1:0] root_in,
  output logic             addr_valid,
  output logic [WIDTH-1:0] addr_out,
  output logic             addr_last,
  output logic             seq_sel,
  output logic             dc_flag,
  output logic             err_flag,
  output logic             busy
);
  localparam int PW = 2 * WIDTH;
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_DC, S_EMIT, S_LOAD, S_RED} state_t;

  state_t           state;
  logic [WIDTH-1:0] n_r, g_r, h_r, cur, idx;
  logic [PW-1:0]    rem;
  logic [CW-1:0]    cnt;
  logic             seq_r, err_r;

  logic [WIDTH-1:0] mult;
  logic [PW-1:0]    trial, rem_nx;
  logic             last_beat, bad_args;

  assign mult      = seq_r ? h_r : g_r;
  assign trial     = {{WIDTH{1'b0}}, n_r} << cnt;
  assign rem_nx    = (rem >= trial) ? rem - trial : rem;
  assign last_beat = (idx == n_r - WIDTH'(2));
  assign bad_args  = (len_in < WIDTH'(2)) || (root_in == '0) || (root_in >= len_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      n_r   <= '0;
      g_r   <= '0;
      h_r   <= '0;
      cur   <= '0;
      idx   <= '0;
      rem   <= '0;
      cnt   <= '0;
      seq_r <= 1'b0;
      err_r <= 1'b0;
    end else if (start) begin
      seq_r <= 1'b0;
      if (bad_args) begin
        state <= S_IDLE;
        err_r <= 1'b1;
      end else begin
        n_r   <= len_in;
        g_r   <= root_in;
        err_r <= 1'b0;
        state <= S_DC;
      end
    end else begin
      case (state)
        S_DC: begin
          cur   <= WIDTH'(1);
          idx   <= '0;
          state <= S_EMIT;
        end
        S_EMIT: begin
          if (last_beat) begin
            if (!seq_r) begin
              h_r   <= cur;
              seq_r <= 1'b1;
              cur   <= WIDTH'(1);
              idx   <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          rem   <= {{WIDTH{1'b0}}, cur} * {{WIDTH{1'b0}}, mult};
          cnt   <= CW'(WIDTH - 1);
          state <= S_RED;
        end
        S_RED: begin
          rem <= rem_nx;
          if (cnt == '0) begin
            cur <= rem_nx[WIDTH-1:0];
            idx <= idx + 1'b1;
            if (!seq_r && rem_nx == PW'(1)) begin
              err_r <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_EMIT;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign addr_valid = (state == S_DC) || (state == S_EMIT);
  assign addr_out   = (state == S_EMIT) ? cur : '0;
  assign addr_last  = (state == S_EMIT) && last_beat;
  assign seq_sel    = seq_r;
  assign dc_flag    = (state == S_DC);
  assign err_flag   = err_r;
  assign busy       = (state != S_IDLE);
endmodule

// File: rtl/rader_perm_gen_chk.sv
module rader_perm_gen_chk #(
  parameter int WIDTH = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             addr_valid,
  input logic [WIDTH-1:0] addr_out,
  input logic             addr_last,
  input logic             seq_sel,
  input logic             dc_flag,
  input logic             err_flag,
  input logic             busy
);
  assert_dc_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dc_flag |-> (addr_valid && addr_out == '0 && !seq_sel && !addr_last));

  assert_dc_then_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_flag && !start) |=> (addr_valid && !dc_flag && !seq_sel && addr_out == WIDTH'(1)));

  assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !dc_flag) |-> (addr_out != '0));

  assert_out_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_last && !seq_sel && !start) |=> (addr_valid && seq_sel && addr_out == WIDTH'(1)));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_last && !dc_flag && !start) |=> !addr_valid);

  assert_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_last && seq_sel && !start) |=> !busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !addr_valid);

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !busy);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dc_flag || (err_flag && !busy)));
endmodule

bind rader_perm_gen rader_perm_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr_valid(addr_valid),
  .addr_out(addr_out), .addr_last(addr_last), .seq_sel(seq_sel),
  .dc_flag(dc_flag), .err_flag(err_flag), .busy(busy)
);

// File: tb/rader_perm_gen_tb.sv
`timescale 1ns/1ps
module rader_perm_gen_tb;
  localparam int W = 5;
  localparam int GAP = W + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] len_in = '0;
  logic [W-1:0] root_in = '0;
  logic         addr_valid, addr_last, seq_sel, dc_flag, err_flag, busy;
  logic [W-1:0] addr_out;

  int checks = 0;
  int failures = 0;

  int b_addr [0:127];
  int b_seq  [0:127];
  int b_last [0:127];
  int b_dc   [0:127];
  int b_cyc  [0:127];
  int nb, end_cyc, end_err, end_busy;

  always #4 clk = ~clk;

  rader_perm_gen #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in), .root_in(root_in),
    .addr_valid(addr_valid), .addr_out(addr_out), .addr_last(addr_last),
    .seq_sel(seq_sel), .dc_flag(dc_flag), .err_flag(err_flag), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int powmod(input int b, input int e, input int n);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % n;
    return r;
  endfunction

  task automatic run_collect(input int n, input int g);
    @(negedge clk);
    len_in = W'(n);
    root_in = W'(g);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (addr_valid && nb < 128) begin
        b_addr[nb] = int'(addr_out);
        b_seq[nb]  = int'(seq_sel);
        b_last[nb] = int'(addr_last);
        b_dc[nb]   = int'(dc_flag);
        b_cyc[nb]  = cyc;
        nb++;
      end
      end_cyc = cyc;
      end_err = int'(err_flag);
      end_busy = int'(busy);
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic verify_prime(input int n, input int g);
    int h, bad_in, bad_out, bad_last, bad_gap;
    bit [31:0] seen_in, seen_out;
    h = powmod(g, n - 2, n);
    bad_in = 0; bad_out = 0; bad_last = 0; bad_gap = 0;
    seen_in = '0; seen_out = '0;
    chk(nb == 2 * n - 1, "R3 beat count", nb, 2 * n - 1);
    chk(b_dc[0] == 1 && b_addr[0] == 0 && b_seq[0] == 0 && b_cyc[0] == 0, "R2 dc beat", b_addr[0], 0);
    if (nb == 2 * n - 1) begin
      if (b_last[0] != 0) bad_last++;
      for (int q = 0; q < n - 1; q++) begin
        if (b_addr[1 + q] != powmod(g, q, n) || b_seq[1 + q] != 0 || b_dc[1 + q] != 0) bad_in++;
        if (b_last[1 + q] != (q == n - 2)) bad_last++;
        if (b_addr[1 + q] > 0 && b_addr[1 + q] < n) seen_in[b_addr[1 + q]] = 1'b1;
        if (b_cyc[1 + q] != 1 + q * GAP) bad_gap++;
      end
      for (int p = 0; p < n - 1; p++) begin
        if (b_addr[n + p] != powmod(h, p, n) || b_seq[n + p] != 1) bad_out++;
        if (b_last[n + p] != (p == n - 2)) bad_last++;
        if (b_addr[n + p] > 0 && b_addr[n + p] < n) seen_out[b_addr[n + p]] = 1'b1;
        if (b_cyc[n + p] != 2 + (n - 2) * GAP + p * GAP) bad_gap++;
      end
      chk(bad_in == 0, "R3 input addresses", bad_in, 0);
      chk(bad_out == 0, "R5 output addresses", bad_out, 0);
      chk(bad_last == 0, "R4 last marking", bad_last, 0);
      chk(bad_gap == 0, "R7 beat spacing", bad_gap, 0);
      chk($countones(seen_in) == n - 1, "R6 input coverage", $countones(seen_in), n - 1);
      chk($countones(seen_out) == n - 1, "R6 output coverage", $countones(seen_out), n - 1);
      chk(end_cyc == b_cyc[nb - 1] + 1, "R11 busy drop", end_cyc, b_cyc[nb - 1] + 1);
    end
    chk(end_err == 0 && end_busy == 0, "R9 clean finish", end_err, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(!addr_valid && !busy && !err_flag, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !busy && !err_flag, "R1 after reset", int'(addr_valid), 0);
  endtask

  task automatic test_all_primes();
    int primes [11] = '{2, 3, 5, 7, 11, 13, 17, 19, 23, 29, 31};
    int roots  [11] = '{1, 2, 2, 3, 2, 2, 3, 2, 5, 2, 3};
    for (int i = 0; i < 11; i++) begin
      run_collect(primes[i], roots[i]);
      verify_prime(primes[i], roots[i]);
    end
  endtask

  task automatic test_not_primitive();
    int extra = 0;
    run_collect(7, 2);
    chk(nb == 4, "R8 beats before stop", nb, 4);
    chk(nb == 4 && b_addr[3] == 4, "R8 last good address", b_addr[3], 4);
    chk(end_err == 1 && end_busy == 0, "R8 error with idle", end_err, 1);
    repeat (20) begin
      @(negedge clk);
      if (addr_valid) extra++;
    end
    chk(extra == 0, "R8 no beats after error", extra, 0);
    chk(err_flag == 1'b1, "R8 error sticky", int'(err_flag), 1);
  endtask

  task automatic test_illegal();
    run_collect(7, 7);
    chk(nb == 0 && end_err == 1, "R9 root equals length", nb, 0);
    run_collect(1, 1);
    chk(nb == 0 && end_err == 1, "R9 length below two", nb, 0);
    run_collect(5, 0);
    chk(nb == 0 && end_err == 1, "R9 zero root", nb, 0);
    run_collect(3, 2);
    verify_prime(3, 2);
  endtask

  task automatic test_restart();
    @(negedge clk);
    len_in = W'(11);
    root_in = W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R10 run in progress", int'(busy), 1);
    run_collect(5, 2);
    chk(nb == 9, "R10 restarted beat count", nb, 9);
    verify_prime(5, 2);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_all_primes();
    test_not_primitive();
    test_illegal();
    test_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule